// File: doc/BRIEF.md
# Bitmap-Programmed ADC Channel Sequencer

This block chooses the analog channel that a shared converter samples next. Software programs a table of seven seven-bit sequence words. Each bit stands for one of channels 0 to 6. The sequencer walks through the table in a fixed order and raises a conversion request for every set bit it finds. It presents the channel number with that request and waits for the converter's done pulse before it moves on. A channel whose bit is set in many words is sampled more often, so the number of set bits decides each channel's share of the converter.

Clear bits are skipped without cost. After a done pulse, the next set bit is found in the same clock cycle, even when it lies several words further on. When the last word has been consumed, the scan wraps back to the first word. A one-cycle marker flags the first request of every pass. Table writes go to a shadow copy, and the sequencer copies that shadow at the start of each pass. A lock input blocks writes. The control state machine has two states. In SQ_IDLE no request is raised and the shadow table is checked on every clock; the move SQ_IDLE to SQ_CONV happens when the shadow holds at least one set bit. SQ_CONV holds a request. On a done pulse it stays in SQ_CONV when a later bit remains in the pass, or when the pass wraps onto a non-empty shadow. It goes back to SQ_IDLE when the pass ends and the shadow is all clear.

Top module: `adc_slot_sequencer`

## Requirements
- R1: While reset is asserted, conv_req and pass_start are low. The table comes out of reset with words 1 to 7 equal to 0110111, 1001000, 0110110, 1001001, 0110110, 1001000 and 0110111 (bit 6 written first), so cfg_rd_lo reads 0x49364837 and cfg_rd_hi reads 0x00374836.
- R2: Scanning runs from word 1 to word 7, and within each word from bit 6 down to bit 0. Bit n stands for channel n. A set bit produces one request for that channel, and a clear bit produces none. With the reset table a pass is the 25 channels 5,4,2,1,0,6,3,5,4,2,1,6,3,0,5,4,2,1,6,3,5,4,2,1,0.
- R3: After a cycle in which conv_ack is high while conv_req is high, conv_req is high in the very next cycle with the next set position's channel, however many clear positions or words lie between.
- R4: While conv_req is high and conv_ack is low, conv_req and conv_ch stay unchanged in the following cycle.
- R5: After word 7 bit 0 the scan returns to word 1 bit 6. pass_start is high for exactly the first cycle of the first request of each pass and low otherwise. A pass with a single set bit raises pass_start on every request.
- R6: While cfg_lock is high, writes leave the table unchanged.
- R7: A write made during a pass does not change the remainder of that pass. It governs the order from the next pass on.
- R8: When a pass ends and the table is all clear, conv_req stays low and conv_ack is ignored. Once a set bit is written, the first request appears in the cycle after the write takes effect, with pass_start high.
- R9: cfg_wr_sel 0 selects the register holding words 1 to 4 in bits [6:0], [14:8], [22:16] and [30:24]. cfg_wr_sel 1 selects the register holding words 5 to 7 in bits [6:0], [14:8] and [22:16]. All other bits are not stored and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Table write strobe, one write per cycle |
| cfg_wr_sel | input | 1 | Register select: 0 words 1-4, 1 words 5-7 |
| cfg_wr_data | input | 32 | Write data, one word per byte lane |
| cfg_lock | input | 1 | Write protection, high blocks writes |
| cfg_rd_lo | output | 32 | Shadow contents of words 1-4 |
| cfg_rd_hi | output | 32 | Shadow contents of words 5-7 |
| conv_ack | input | 1 | Conversion-done pulse from the converter |
| conv_req | output | 1 | Conversion request valid |
| conv_ch | output | 3 | Channel number to convert |
| pass_start | output | 1 | High on the first cycle of a pass's first request |

## Verification
Every result is due one clock edge after the stimulus that causes it. A done pulse sampled at an edge moves conv_ch and pass_start at that same edge. A write updates the readback at its edge. A write that fills an empty table raises conv_req one edge later. The bench drives each stimulus for exactly one cycle from a falling edge. It compares outputs at the following falling edge, after the single register stage has settled. Tests that involve holding or idling wait several extra falling edges and check that nothing has moved.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned SEQ_WORDS = 7;
    localparam int unsigned SEQ_CH    = 7;
    localparam int unsigned SEQ_SLOTS = SEQ_WORDS * SEQ_CH;
    localparam int unsigned SLOT_W    = $clog2(SEQ_SLOTS + 1);
    localparam int unsigned CH_W      = $clog2(SEQ_CH);
    localparam int unsigned REG_W     = 32;
    localparam int unsigned LANE_W    = 8;
    localparam int unsigned LANES     = REG_W / LANE_W;
    localparam int unsigned REGS      = (SEQ_WORDS + LANES - 1) / LANES;
    localparam int unsigned SEL_W     = (REGS > 1) ? $clog2(REGS) : 1;

    typedef logic [SEQ_CH-1:0]                 seq_word_t;
    typedef logic [SEQ_WORDS-1:0][SEQ_CH-1:0]  seq_tbl_t;

    typedef enum logic [0:0] {
        SQ_IDLE,
        SQ_CONV
    } seq_state_e;

    // power-up table: words indexed from 0 (word 1)
    function automatic seq_word_t seq_reset_word(input int w);
        case (w)
            0:       return 7'b0110111;
            1:       return 7'b1001000;
            2:       return 7'b0110110;
            3:       return 7'b1001001;
            4:       return 7'b0110110;
            5:       return 7'b1001000;
            6:       return 7'b0110111;
            default: return '0;
        endcase
    endfunction

    // slot s covers word s/SEQ_CH, scanning from the top channel down
    function automatic logic [CH_W-1:0] slot_to_ch(input logic [SLOT_W-1:0] s);
        logic [SLOT_W-1:0] r;
        r = s % SLOT_W'(SEQ_CH);
        return CH_W'(int'(SEQ_CH) - 1 - int'(r));
    endfunction

endpackage

// File: rtl/adc_seq_table.sv
module adc_seq_table
    import adc_seq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [REG_W-1:0]           wr_data,
    input  logic                       lock,
    output seq_tbl_t                   words,
    output logic [REGS-1:0][REG_W-1:0] rd_regs
);

    seq_tbl_t word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < int'(SEQ_WORDS); w++) begin
                word_q[w] <= seq_reset_word(w);
            end
        end else if (wr_en && !lock) begin
            for (int w = 0; w < int'(SEQ_WORDS); w++) begin
                if (wr_sel == SEL_W'(w / int'(LANES))) begin
                    word_q[w] <= wr_data[(w % int'(LANES)) * int'(LANE_W) +: SEQ_CH];
                end
            end
        end
    end

    always_comb begin
        rd_regs = '0;
        for (int w = 0; w < int'(SEQ_WORDS); w++) begin
            rd_regs[w / int'(LANES)][(w % int'(LANES)) * int'(LANE_W) +: SEQ_CH] = word_q[w];
        end
    end

    assign words = word_q;

    AST_LOCK_HOLDS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(word_q)); // R6

    AST_IDLE_BUS_HOLDS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(word_q)); // R9

endmodule

// File: rtl/adc_seq_slot_map.sv
module adc_seq_slot_map
    import adc_seq_pkg::*;
(
    input  seq_tbl_t               tbl,
    output logic [SEQ_SLOTS-1:0]   slots
);

    // scan position w*SEQ_CH + b holds word w, channel SEQ_CH-1-b
    for (genvar w = 0; w < int'(SEQ_WORDS); w++) begin : g_word
        for (genvar b = 0; b < int'(SEQ_CH); b++) begin : g_bit
            assign slots[w * int'(SEQ_CH) + b] = tbl[w][int'(SEQ_CH) - 1 - b];
        end
    end

endmodule

// File: rtl/adc_seq_first_hit.sv
module adc_seq_first_hit #(
    parameter int unsigned N  = 49,
    parameter int unsigned IW = 6
) (
    input  logic [N-1:0]  bits,
    input  logic [IW-1:0] start,
    output logic          hit,
    output logic [IW-1:0] idx
);

    // lowest set position at or above start
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (bits[i] && (i >= int'(start))) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/adc_slot_sequencer.sv
module adc_slot_sequencer
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_wr_sel,
    input  logic [REG_W-1:0]  cfg_wr_data,
    input  logic              cfg_lock,
    output logic [REG_W-1:0]  cfg_rd_lo,
    output logic [REG_W-1:0]  cfg_rd_hi,
    input  logic              conv_ack,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_ch,
    output logic              pass_start
);

    seq_tbl_t                   shadow_tbl;
    logic [REGS-1:0][REG_W-1:0] rd_regs;
    logic [SEQ_SLOTS-1:0]       slots_act;
    logic [SEQ_SLOTS-1:0]       slots_shd;

    seq_state_e          state_q, state_d;
    seq_tbl_t            active_q, active_d;
    logic [SLOT_W-1:0]   pos_q, pos_d;
    logic                ps_q, ps_d;

    logic                next_hit;
    logic [SLOT_W-1:0]   next_idx;
    logic                first_hit;
    logic [SLOT_W-1:0]   first_idx;
    logic [SLOT_W-1:0]   search_from;

    adc_seq_table u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .lock    (cfg_lock),
        .words   (shadow_tbl),
        .rd_regs (rd_regs)
    );

    assign cfg_rd_lo = rd_regs[0];
    assign cfg_rd_hi = rd_regs[REGS-1];

    adc_seq_slot_map u_map_act (
        .tbl   (active_q),
        .slots (slots_act)
    );

    adc_seq_slot_map u_map_shd (
        .tbl   (shadow_tbl),
        .slots (slots_shd)
    );

    assign search_from = SLOT_W'(pos_q + SLOT_W'(1));

    adc_seq_first_hit #(.N(SEQ_SLOTS), .IW(SLOT_W)) u_next (
        .bits  (slots_act),
        .start (search_from),
        .hit   (next_hit),
        .idx   (next_idx)
    );

    adc_seq_first_hit #(.N(SEQ_SLOTS), .IW(SLOT_W)) u_first (
        .bits  (slots_shd),
        .start ('0),
        .hit   (first_hit),
        .idx   (first_idx)
    );

    // next-state decision
    always_comb begin
        state_d  = state_q;
        active_d = active_q;
        pos_d    = pos_q;
        ps_d     = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (first_hit) begin
                    state_d  = SQ_CONV;
                    active_d = shadow_tbl;
                    pos_d    = first_idx;
                    ps_d     = 1'b1;
                end
            end
            SQ_CONV: begin
                if (conv_ack) begin
                    if (next_hit) begin
                        pos_d = next_idx;
                    end else if (first_hit) begin
                        active_d = shadow_tbl;
                        pos_d    = first_idx;
                        ps_d     = 1'b1;
                    end else begin
                        state_d = SQ_IDLE;
                    end
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            active_q <= '0;
            pos_q    <= '0;
            ps_q     <= 1'b0;
        end else begin
            state_q  <= state_d;
            active_q <= active_d;
            pos_q    <= pos_d;
            ps_q     <= ps_d;
        end
    end

    // outputs
    always_comb begin
        conv_req   = (state_q == SQ_CONV);
        conv_ch    = slot_to_ch(pos_q);
        pass_start = ps_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && !conv_ack |=> conv_req && $stable(conv_ch)); // R4

    AST_PASS_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        pass_start |-> conv_req); // R5

    AST_PASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_start && !conv_ack |=> !pass_start); // R5

    AST_REQ_NEEDS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (active_q != '0)); // R8

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q < SLOT_W'(SEQ_SLOTS)); // R2

    AST_ISSUED_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> slots_act[pos_q]); // R2

    AST_PASS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && !(conv_ack && !next_hit) |=> $stable(active_q)); // R7

    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && conv_ack && next_hit |=> conv_req); // R3

endmodule

// File: tb/adc_slot_sequencer_tb_top.sv
`timescale 1ns/1ps
module adc_slot_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [0:0]  cfg_wr_sel = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        cfg_lock = 1'b0;
    logic [31:0] cfg_rd_lo;
    logic [31:0] cfg_rd_hi;
    logic        conv_ack = 1'b0;
    logic        conv_req;
    logic [2:0]  conv_ch;
    logic        pass_start;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    adc_slot_sequencer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_sel  (cfg_wr_sel),
        .cfg_wr_data (cfg_wr_data),
        .cfg_lock    (cfg_lock),
        .cfg_rd_lo   (cfg_rd_lo),
        .cfg_rd_hi   (cfg_rd_hi),
        .conv_ack    (conv_ack),
        .conv_req    (conv_req),
        .conv_ch     (conv_ch),
        .pass_start  (pass_start)
    );

    // default pass: {pass_start, channel}
    localparam logic [3:0] VEC [25] = '{
        4'hD, 4'h4, 4'h2, 4'h1, 4'h0, 4'h6, 4'h3, 4'h5, 4'h4, 4'h2,
        4'h1, 4'h6, 4'h3, 4'h0, 4'h5, 4'h4, 4'h2, 4'h1, 4'h6, 4'h3,
        4'h5, 4'h4, 4'h2, 4'h1, 4'h0
    };

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_ack();
        conv_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        conv_ack = 1'b0;
    endtask

    task automatic do_write(input logic sel, input logic [31:0] data);
        cfg_wr_en   = 1'b1;
        cfg_wr_sel  = sel;
        cfg_wr_data = data;
        @(posedge clk);
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic chk_slot(input string req, input logic [2:0] ch, input logic ps);
        chk(req, "conv_req", longint'(conv_req), 1);
        chk(req, "conv_ch", longint'(conv_ch), longint'(ch));
        chk(req, "pass_start", longint'(pass_start), longint'(ps));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state and R9 readback layout
        chk("R1", "conv_req in reset", longint'(conv_req), 0);
        chk("R1", "pass_start in reset", longint'(pass_start), 0);
        chk("R1", "rd_lo reset", longint'(cfg_rd_lo), 64'h49364837);
        chk("R9", "rd_hi reset", longint'(cfg_rd_hi), 64'h00374836);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5: two full default passes through the vector table
        for (int p = 0; p < 50; p++) begin
            chk_slot(p < 25 ? "R2" : "R5", VEC[p % 25][2:0], VEC[p % 25][3]);
            if (p == 3) begin
                repeat (3) @(negedge clk);
                chk_slot("R4", VEC[3][2:0], 1'b0);
            end
            pulse_ack();
        end
        chk_slot("R5", 3'd5, 1'b1);

        // R6: locked writes ignored
        cfg_lock = 1'b1;
        do_write(1'b0, 32'h0);
        do_write(1'b1, 32'h0);
        cfg_lock = 1'b0;
        chk("R6", "rd_lo locked", longint'(cfg_rd_lo), 64'h49364837);
        chk("R6", "rd_hi locked", longint'(cfg_rd_hi), 64'h00374836);
        chk_slot("R4", 3'd5, 1'b0);

        for (int k = 1; k <= 3; k++) begin
            pulse_ack();
            chk_slot("R3", VEC[k][2:0], 1'b0);
        end

        // R7 R9: mid-pass write with unused bits set
        do_write(1'b0, 32'h8080_8088);
        do_write(1'b1, 32'hFF80_8080);
        chk("R9", "rd_lo unused bits", longint'(cfg_rd_lo), 64'h00000008);
        chk("R9", "rd_hi unused bits", longint'(cfg_rd_hi), 64'h0);
        for (int i = 3; i < 25; i++) begin
            chk_slot("R7", VEC[i][2:0], 1'b0);
            pulse_ack();
        end
        chk_slot("R7", 3'd3, 1'b1);
        pulse_ack();
        chk_slot("R5", 3'd3, 1'b1);

        // R8: empty table stops requests
        do_write(1'b0, 32'h0);
        chk_slot("R7", 3'd3, 1'b0);
        pulse_ack();
        chk("R8", "conv_req empty", longint'(conv_req), 0);
        repeat (4) @(negedge clk);
        chk("R8", "conv_req still idle", longint'(conv_req), 0);
        chk("R8", "pass_start idle", longint'(pass_start), 0);
        pulse_ack();
        chk("R8", "ack ignored when idle", longint'(conv_req), 0);

        // R8 restart, R3 cross-word skip: word7 bit0 then word1 bit6
        do_write(1'b1, 32'h0001_0000);
        do_write(1'b0, 32'h0000_0040);
        chk_slot("R8", 3'd0, 1'b1);
        pulse_ack();
        chk_slot("R3", 3'd6, 1'b1);
        pulse_ack();
        chk_slot("R3", 3'd0, 1'b0);
        pulse_ack();
        chk_slot("R5", 3'd6, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule